// File: doc/BRIEF.md
# Fixed-Point Function Evaluator

This unit sits on a simple synchronous register bus and evaluates one of four functions on a 32-bit argument. Each function has its own word address. The host writes the argument to a function's address and later reads the answer back from that same address. Address 0 returns the argument unchanged. Address 1 returns an exact integer reciprocal of an argument the host has already normalized. Addresses 2 and 3 return the sine and the cosine of an angle in binary units, as signed fixed-point words with 16 fractional bits.

The reciprocal is computed by a bit-serial restoring divider, one quotient bit per cycle. Sine and cosine come from an iterative rotation (CORDIC) engine. The engine works on the angle reduced to one quadrant and then maps the result back by symmetry. Only one computation is in flight at a time. A write to any address abandons it and starts over with the new argument. A read of the address whose answer is still being computed holds the bus with a wait output until the answer has been stored. Every address keeps its own last completed answer in a small result memory.

Top module: `fixfn_unit`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `rd_data` is 0. `rd_stall` is 0 whenever `rd_en` is 0.
- R2: The 2-bit word address picks the function: 0 passes the argument through, 1 is the reciprocal, 2 is sine, 3 is cosine.
- R3: A read of address 0 returns exactly the last word written to address 0.
- R4: For an argument x with bit 31 set, address 1 returns floor(2^62 / x) with no error. An argument of 0x80000000 gives 0x80000000.
- R5: For an argument a from 0 to 2^31, address 2 returns round(sin(a*pi/2^31)*65536) within 2 LSB, as a two's-complement word.
- R6: For an argument a from 0 to 2^31, address 3 returns round(cos(a*pi/2^31)*65536) within 2 LSB, as a two's-complement word.
- R7: Cosine of argument 0 returns exactly 65536, and sine of argument 0x40000000 returns exactly 65536.
- R8: A read is taken at a rising edge where `rd_en` is 1 and `rd_stall` is 0, and `rd_data` shows the addressed result after that edge. `rd_stall` is 1 while the addressed function is still computing, and also while `rd_en` and `wr_en` are high together. After a write, a wait lasts at most 33 cycles.
- R9: A write to an address whose computation is in progress restarts it, and the next read returns the answer for the newer argument.
- R10: A write to a different address abandons the computation in progress. The abandoned address keeps its previous completed answer, and a read of it in the cycle after that write does not stall.
- R11: `rd_data` keeps its value in every cycle in which no read is taken, including while writes and computations go on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Word address, selects the function for both writes and reads |
| wr_en | input | 1 | Write strobe: capture `wr_data` as the argument and start evaluation |
| wr_data | input | 32 | Argument word |
| rd_en | input | 1 | Read strobe, held until `rd_stall` is low |
| rd_stall | output | 1 | Wait: the read cannot be taken this cycle |
| rd_data | output | 32 | Registered read data |

## Verification
The hardest case to reach from the ports is an abandoned computation. One case is a second write to the same address while the divider is partway through its quotient bits. The other is a write to another address straight after a reciprocal write, which must leave the earlier reciprocal answer readable without a wait. The stimulus reaches both by issuing back-to-back writes a fixed few cycles apart, with no read in between. It then reads both addresses and compares them with expected answers queued in advance. The exact corner points are also driven directly: a reciprocal of 2^31, cosine at zero, sine at a quarter turn, and a half-turn angle.

// File: rtl/fixfn_pkg.sv
`timescale 1ns/1ps
package fixfn_pkg;

  localparam int DATA_W  = 32;
  localparam int SLOT_W  = 2;
  localparam int N_SLOTS = 1 << SLOT_W;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_PASS  = 2'd0,
    SLOT_RECIP = 2'd1,
    SLOT_SIN   = 2'd2,
    SLOT_COS   = 2'd3
  } slot_e;

  // Inverse rotation gain of the CORDIC, scaled by 2^30.
  localparam logic [DATA_W-1:0] CORDIC_GAIN_Q30 = 32'd652032874;

  // 2^63 / pi, used to build the arctangent constants.
  localparam logic [63:0] INV_PI_Q63 = 64'd2935890503282001227;

  // atan(2^-idx) in angle units where 2^(DATA_W-1) is a half turn.
  function automatic logic [DATA_W-1:0] atan_units(input int idx);
    logic [63:0] acc;
    logic [63:0] term;
    int          sh;
    acc = 64'd0;
    if (idx == 0) return DATA_W'(64'd1 << (DATA_W - 3));
    for (int n = 0; n < 32; n++) begin
      sh = (2 * n + 1) * idx;
      if (sh < 63) begin
        term = (INV_PI_Q63 >> sh) / 64'(2 * n + 1);
        if (n % 2 == 0) acc = acc + term;
        else            acc = acc - term;
      end
    end
    return DATA_W'((acc + (64'd1 << 31)) >> 32);
  endfunction

endpackage

// File: rtl/fixfn_recip.sv
`timescale 1ns/1ps
module fixfn_recip
  import fixfn_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] divisor,
  input  logic              step,
  output logic [DATA_W-1:0] quot
);
  // Dividend is 2^(2*DATA_W-2); the remainder starts with its upper half.
  localparam logic [DATA_W-1:0] REM_START = DATA_W'(1) << (DATA_W - 2);

  logic [DATA_W-1:0] den;
  logic [DATA_W-1:0] rem;
  logic [DATA_W:0]   rem_sh;
  logic              take;

  assign rem_sh = {rem, 1'b0};
  assign take   = rem_sh >= {1'b0, den};

  always_ff @(posedge clk) begin
    if (rst) begin
      den  <= '0;
      rem  <= '0;
      quot <= '0;
    end else if (load) begin
      den  <= divisor;
      rem  <= REM_START;
      quot <= '0;
    end else if (step) begin
      rem  <= take ? DATA_W'(rem_sh - {1'b0, den}) : DATA_W'(rem_sh);
      quot <= {quot[DATA_W-2:0], take};
    end
  end
endmodule

// File: rtl/fixfn_cordic.sv
`timescale 1ns/1ps
module fixfn_cordic
  import fixfn_pkg::*;
#(
  parameter int STEPS    = 24,
  parameter int OUT_FRAC = 16,
  parameter int IDX_W    = 6
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] angle,
  input  logic              step,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] sin_q,
  output logic [DATA_W-1:0] cos_q
);
  localparam int FRAC    = DATA_W - 2;       // quarter turn = 2^FRAC, unit vector = 2^FRAC
  localparam int VW      = FRAC + 4;
  localparam int ZW      = DATA_W + 1;
  localparam int SH      = FRAC - OUT_FRAC;
  localparam int TAB_N   = 1 << IDX_W;
  localparam logic signed [VW-1:0] X_START = VW'(CORDIC_GAIN_Q30);
  localparam logic signed [VW-1:0] HALF    = VW'(1) <<< (SH - 1);

  logic [DATA_W-1:0] atan_tab [TAB_N];

  for (genvar g = 0; g < TAB_N; g++) begin : g_atan
    if (g < STEPS) begin : g_used
      assign atan_tab[g] = atan_units(g);
    end else begin : g_pad
      assign atan_tab[g] = '0;
    end
  end

  logic signed [VW-1:0] vx, vy;
  logic signed [ZW-1:0] vz;
  logic [1:0]           quad;
  logic signed [VW-1:0] vx_sh, vy_sh;
  logic signed [ZW-1:0] ang;

  assign vx_sh = vx >>> idx;
  assign vy_sh = vy >>> idx;
  assign ang   = $signed({1'b0, atan_tab[idx]});

  always_ff @(posedge clk) begin
    if (rst) begin
      vx   <= '0;
      vy   <= '0;
      vz   <= '0;
      quad <= '0;
    end else if (load) begin
      vx   <= X_START;
      vy   <= '0;
      vz   <= $signed({{(ZW-FRAC){1'b0}}, angle[FRAC-1:0]});
      quad <= angle[DATA_W-1 -: 2];
    end else if (step) begin
      if (!vz[ZW-1]) begin
        vx <= vx - vy_sh;
        vy <= vy + vx_sh;
        vz <= vz - ang;
      end else begin
        vx <= vx + vy_sh;
        vy <= vy - vx_sh;
        vz <= vz + ang;
      end
    end
  end

  // Round the first-quadrant results to OUT_FRAC bits, then fold by quadrant.
  logic signed [VW-1:0]     x_rnd, y_rnd;
  logic signed [DATA_W-1:0] c0, s0;

  assign x_rnd = (vx + HALF) >>> SH;
  assign y_rnd = (vy + HALF) >>> SH;
  assign c0    = DATA_W'(x_rnd);
  assign s0    = DATA_W'(y_rnd);

  always_comb begin
    unique case (quad)
      2'd0: begin sin_q = s0;  cos_q = c0;  end
      2'd1: begin sin_q = c0;  cos_q = -s0; end
      2'd2: begin sin_q = -s0; cos_q = -c0; end
      default: begin sin_q = -c0; cos_q = s0; end
    endcase
  end
endmodule

// File: rtl/fixfn_bank.sv
`timescale 1ns/1ps
module fixfn_bank #(
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int W     = 32
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fixfn_unit.sv
`timescale 1ns/1ps
module fixfn_unit
  import fixfn_pkg::*;
#(
  parameter int TRIG_STEPS = 24,
  parameter int OUT_FRAC   = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic              rd_stall,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LONGEST = (DATA_W > TRIG_STEPS) ? DATA_W : TRIG_STEPS;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] RECIP_LAST = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] TRIG_LAST  = CNT_W'(TRIG_STEPS);

  slot_e            req_slot;
  slot_e            cur_slot;
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;
  logic             finish;
  logic             advance;

  assign req_slot = slot_e'(addr);
  assign last_cnt = (cur_slot == SLOT_RECIP) ? RECIP_LAST : TRIG_LAST;
  assign finish   = busy && !wr_en && (cnt == last_cnt);
  assign advance  = busy && !wr_en && (cnt != last_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cur_slot <= SLOT_PASS;
      cnt      <= '0;
    end else if (wr_en) begin
      busy     <= (req_slot != SLOT_PASS);
      cur_slot <= req_slot;
      cnt      <= '0;
    end else if (finish) begin
      busy     <= 1'b0;
    end else if (advance) begin
      cnt      <= cnt + 1'b1;
    end
  end

  logic [DATA_W-1:0] recip_q, sin_q, cos_q;

  fixfn_recip u_recip (
    .clk     (clk),
    .rst     (rst),
    .load    (wr_en),
    .divisor (wr_data),
    .step    (advance && (cur_slot == SLOT_RECIP)),
    .quot    (recip_q)
  );

  fixfn_cordic #(
    .STEPS    (TRIG_STEPS),
    .OUT_FRAC (OUT_FRAC),
    .IDX_W    (CNT_W)
  ) u_cordic (
    .clk   (clk),
    .rst   (rst),
    .load  (wr_en),
    .angle (wr_data),
    .step  (advance && (cur_slot == SLOT_SIN || cur_slot == SLOT_COS)),
    .idx   (cnt),
    .sin_q (sin_q),
    .cos_q (cos_q)
  );

  logic [DATA_W-1:0] eng_res;
  always_comb begin
    unique case (cur_slot)
      SLOT_RECIP: eng_res = recip_q;
      SLOT_SIN:   eng_res = sin_q;
      SLOT_COS:   eng_res = cos_q;
      default:    eng_res = '0;
    endcase
  end

  assign rd_stall = rd_en && (wr_en || (busy && req_slot == cur_slot));

  fixfn_bank #(
    .DEPTH (N_SLOTS),
    .AW    (SLOT_W),
    .W     (DATA_W)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    ((wr_en && req_slot == SLOT_PASS) || finish),
    .waddr (wr_en ? addr : cur_slot),
    .wdata (wr_en ? wr_data : eng_res),
    .re    (rd_en && !rd_stall),
    .raddr (addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/fixfn_unit_chk.sv
`timescale 1ns/1ps
module fixfn_unit_chk
  import fixfn_pkg::*;
#(
  parameter int TRIG_STEPS = 24
)(
  input logic              clk,
  input logic              rst,
  input logic [SLOT_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic              rd_stall,
  input logic [DATA_W-1:0] rd_data
);
  localparam int LONGEST = (DATA_W > TRIG_STEPS) ? DATA_W : TRIG_STEPS;
  localparam int MAX_RUN = LONGEST + 1;

  logic [15:0]       stall_run;
  logic [DATA_W-1:0] pass_shadow;
  logic              pass_known;
  logic              pass_read_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_run   <= '0;
      pass_shadow <= '0;
      pass_known  <= 1'b0;
      pass_read_q <= 1'b0;
    end else begin
      stall_run   <= (rd_stall && !wr_en) ? stall_run + 16'd1 : 16'd0;
      pass_read_q <= rd_en && !rd_stall && (addr == SLOT_PASS);
      if (wr_en && addr == SLOT_PASS) begin
        pass_shadow <= wr_data;
        pass_known  <= 1'b1;
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0));

  assert_stall_needs_read_R8: assert property (@(posedge clk) disable iff (rst)
    rd_stall |-> rd_en);

  assert_stall_bound_R8: assert property (@(posedge clk) disable iff (rst)
    stall_run <= 16'(MAX_RUN));

  assert_hold_data_R11: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !rd_stall) |=> $stable(rd_data));

  assert_pass_value_R3: assert property (@(posedge clk) disable iff (rst)
    (pass_read_q && pass_known) |-> (rd_data == pass_shadow));

  assert_other_slot_free_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && rd_en && !wr_en && (addr != $past(addr))) |-> !rd_stall);
endmodule

bind fixfn_unit fixfn_unit_chk #(.TRIG_STEPS(TRIG_STEPS)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .addr     (addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_stall (rd_stall),
  .rd_data  (rd_data)
);

// File: tb/fixfn_unit_tb_top.sv
`timescale 1ns/1ps
module fixfn_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  addr;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        rd_en;
  logic        rd_stall;
  logic [31:0] rd_data;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [31:0] exp;
    int          tol;
    string       tag;
  } item_t;

  item_t sb_q[$];

  always #4 clk = ~clk;   // 125 MHz

  fixfn_unit dut_i (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_stall (rd_stall),
    .rd_data  (rd_data)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] recip_ref(input logic [31:0] x);
    logic [63:0] num;
    num = 64'd1 << 62;
    return 32'(num / {32'd0, x});
  endfunction

  function automatic logic [31:0] trig_ref(input bit use_cos, input logic [31:0] a);
    real th;
    real v;
    int  r;
    th = real'(a) * 3.14159265358979323846 / 2147483648.0;
    v  = (use_cos ? $cos(th) : $sin(th)) * 65536.0;
    r  = int'(v);
    return 32'(r);
  endfunction

  // Driver tasks: each starts and ends just after a rising edge.
  task automatic put_write(input logic [1:0] s, input logic [31:0] a);
    addr = s; wr_data = a; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic take_read(input logic [1:0] s, output int stalls);
    bit st;
    addr = s; rd_en = 1'b1; stalls = 0;
    while (1) begin
      @(negedge clk);
      st = rd_stall;
      @(posedge clk); #1;
      if (!st) break;
      stalls++;
    end
    rd_en = 1'b0;
  endtask

  task automatic expect_read(input logic [1:0] s, input logic [31:0] e, input int tol,
                             input string tag, output int stalls);
    item_t it;
    it.exp = e; it.tol = tol; it.tag = tag;
    sb_q.push_back(it);
    take_read(s, stalls);
  endtask

  task automatic run_eval(input logic [1:0] s, input logic [31:0] a, input logic [31:0] e,
                          input int tol, input string tag, output int stalls);
    put_write(s, a);
    expect_read(s, e, tol, tag, stalls);
  endtask

  // Monitor: compares each taken read with the head of the scoreboard.
  initial begin : monitor
    bit    pend;
    item_t it;
    longint diff;
    pend = 1'b0;
    forever begin
      @(negedge clk);
      if (pend) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R8 read taken with nothing expected", longint'(rd_data), 0);
        end else begin
          it = sb_q.pop_front();
          if (it.tol == 0) begin
            check(rd_data == it.exp, it.tag, longint'(rd_data), longint'(it.exp));
          end else begin
            diff = longint'($signed(rd_data)) - longint'($signed(it.exp));
            if (diff < 0) diff = -diff;
            check(diff <= it.tol, it.tag, longint'($signed(rd_data)), longint'($signed(it.exp)));
          end
        end
      end
      pend = rd_en && !rd_stall && !rst;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    int          st;
    logic [31:0] a;
    logic [31:0] held;
    rst = 1'b1; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(rd_data == 32'd0, "R1 rd_data after reset", longint'(rd_data), 0);
    check(rd_stall == 1'b0, "R1 rd_stall idle", longint'(rd_stall), 0);
    @(posedge clk); #1;

    // R2 R3: pass-through slot
    run_eval(2'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, "R3 pass deadbeef", st);
    check(st == 0, "R3 pass read does not wait", st, 0);
    run_eval(2'd0, 32'h0000_0000, 32'h0000_0000, 0, "R3 pass zero", st);
    run_eval(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3 pass ones", st);
    run_eval(2'd0, 32'h1234_5678, 32'h1234_5678, 0, "R2 R3 pass pattern", st);

    // R4 R7 R8: reciprocal with stall on immediate read
    run_eval(2'd1, 32'h8000_0000, 32'h8000_0000, 0, "R4 recip of 2^31", st);
    check(st > 0 && st <= 33, "R8 stall length after recip write", st, 33);
    run_eval(2'd1, 32'hFFFF_FFFF, recip_ref(32'hFFFF_FFFF), 0, "R4 recip max", st);
    run_eval(2'd1, 32'hC000_0000, 32'd1431655765, 0, "R4 recip three quarters", st);
    run_eval(2'd1, 32'h8000_0001, recip_ref(32'h8000_0001), 0, "R4 recip just above 2^31", st);
    for (int k = 0; k < 64; k++) begin
      a = 32'h8000_0000 + 32'(k) * 32'h0200_0000 + 32'(k) * 32'h0000_1357;
      run_eval(2'd1, a, recip_ref(a), 0, "R4 recip sweep", st);
    end

    // R7 exact trig points, R8 trig stall bound
    run_eval(2'd3, 32'h0000_0000, 32'd65536, 0, "R7 cos of zero", st);
    check(st > 0 && st <= 25, "R8 stall length after trig write", st, 25);
    run_eval(2'd2, 32'h4000_0000, 32'd65536, 0, "R7 sin of quarter turn", st);
    run_eval(2'd3, 32'h8000_0000, trig_ref(1'b1, 32'h8000_0000), 2, "R6 cos of half turn", st);
    run_eval(2'd2, 32'h8000_0000, trig_ref(1'b0, 32'h8000_0000), 2, "R5 sin of half turn", st);

    // R5 R6 sweeps over 0..2^31
    for (int k = 0; k <= 128; k++) begin
      a = 32'(k) * 32'h0100_0000 + ((k % 2 == 1) ? 32'h0003_1415 : 32'h0);
      run_eval(2'd2, a, trig_ref(1'b0, a), 2, "R5 sin sweep", st);
      run_eval(2'd3, a, trig_ref(1'b1, a), 2, "R6 cos sweep", st);
    end

    // R9: restart the same slot mid-computation
    put_write(2'd1, 32'h9000_0000);
    repeat (5) @(posedge clk);
    #1;
    run_eval(2'd1, 32'hA5A5_0001, recip_ref(32'hA5A5_0001), 0, "R9 recip restarted", st);
    put_write(2'd2, 32'h1000_0000);
    repeat (3) @(posedge clk);
    #1;
    run_eval(2'd2, 32'h2000_0000, trig_ref(1'b0, 32'h2000_0000), 2, "R9 sin restarted", st);

    // R10: abandon by another slot keeps the earlier answer
    run_eval(2'd1, 32'hB000_0000, recip_ref(32'hB000_0000), 0, "R10 recip baseline", st);
    put_write(2'd1, 32'hF000_0000);
    put_write(2'd2, 32'h3000_0000);
    expect_read(2'd1, recip_ref(32'hB000_0000), 0, "R10 abandoned slot keeps answer", st);
    check(st == 0, "R10 abandoned slot read without wait", st, 0);
    expect_read(2'd2, trig_ref(1'b0, 32'h3000_0000), 2, "R10 new slot answer", st);

    // R10 independence: other slots untouched
    expect_read(2'd0, 32'h1234_5678, 0, "R10 pass slot kept", st);
    expect_read(2'd3, trig_ref(1'b1, 32'h8000_0000 - 32'h8000_0000 + 32'h8000_0000), 2,
                "R10 cos slot kept", st);

    // R11: rd_data holds while writes and computations run
    @(negedge clk);
    held = rd_data;
    @(posedge clk); #1;
    put_write(2'd1, 32'hC123_4567);
    put_write(2'd0, 32'h5555_AAAA);
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(rd_data == held, "R11 rd_data held without read", longint'(rd_data), longint'(held));
    @(posedge clk); #1;
    expect_read(2'd0, 32'h5555_AAAA, 0, "R11 later read updates", st);

    repeat (4) @(posedge clk);
    check(sb_q.size() == 0, "R8 all expected reads taken", sb_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule